// File: doc/BRIEF.md
# Set/Clear Aliased Control Register Bank

This block holds a small bank of 32-bit control registers behind an APB slave port and presents every stored value in parallel to the peripheral logic around it. Software that changes a single control bit should not have to read the register, edit the value and write it back. So each register is reachable through three word addresses: a set alias, a clear alias and a read alias.

A write to the set alias turns on every bit where the write data holds a 1. A write to the clear alias turns off every bit where the write data holds a 1. A 0 in the write data leaves the matching bit alone at either alias. The read alias returns the stored value.

Register k owns a 16-byte slot that starts at byte offset `16*k` inside the block's own address window. Inside the slot the aliases come in this order: set at +0x0, clear at +0x4, read at +0x8. The fourth word, +0xC, is a spare. The peripheral bus decodes the window and drives PSEL. This block only looks at the offset bits inside the window.

Top module: `setclr_regbank`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every register bit is cleared to 0 at that edge, and `reg_q` shows all zeros afterwards.
- R2: A write to offset `16*k + 0x0` (the set alias) makes bit i of register k equal to 1 wherever `pwdata[i]` is 1, and leaves the bits where `pwdata[i]` is 0 unchanged.
- R3: A write to offset `16*k + 0x4` (the clear alias) makes bit i of register k equal to 0 wherever `pwdata[i]` is 1, and leaves the bits where `pwdata[i]` is 0 unchanged.
- R4: During a read access, `prdata` equals the current value of register k when the address is offset `16*k + 0x8` (the read alias). A write to that offset changes no register.
- R5: A read from a set alias, a clear alias, a spare word (`16*k + 0xC`) or any offset beyond the last register returns 0 on `prdata`.
- R6: A register changes only at the rising edge where `psel`, `penable` and `pwrite` are all high. A setup phase on its own (`psel` high, `penable` low) changes nothing, even when it is held for several cycles.
- R7: A write to register k changes no register other than k. Register k is exported on `reg_q[32*k +: 32]`.
- R8: `pready` is 1 in every cycle, so every access finishes with no wait state.
- R9: A write to a spare word, or to any offset whose slot index is `NUM_REGS` or higher, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| psel | input | 1 | Slave select, driven by the bus decoder for this block's window |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (8) | Byte offset inside the window. Bits [1:0] are ignored. |
| pwdata | input | DATA_W (32) | Write data, used as a bit mask at the set and clear aliases |
| prdata | output | DATA_W (32) | Read data. Zero unless a read alias is being read. |
| pready | output | 1 | Access complete. Always 1. |
| reg_q | output | NUM_REGS*DATA_W (128) | Stored register values, register k in bits [32*k +: 32] |

## Verification
The embedded assertions check, on every clock cycle, four properties:
- A set or clear strobe reaches its register with the right mask effect on the following cycle.
- The decoder never strobes more than one register alias at once.
- The exported registers stay stable in any cycle without a completed write.
- `prdata` is non-zero only while a read alias is being read.

Only the bench's directed scenarios can show the rest:
- The concrete address map: which offset reaches which register and which alias.
- The reset value.
- That a long setup phase alone writes nothing.
- That spare and out-of-range writes are dropped, compared against values the bench models independently.

// File: rtl/setclr_pkg.sv
// Package: shared definitions for the set/clear aliased register bank.
// Assumes a 16-byte slot per register, with the alias selected by byte
// offset bits [3:2].
package setclr_pkg;

    // Alias selected inside one 16-byte register slot. Encoded by paddr[3:2].
    typedef enum logic [1:0] {
        SLOT_SET   = 2'd0,
        SLOT_CLR   = 2'd1,
        SLOT_READ  = 2'd2,
        SLOT_SPARE = 2'd3
    } slot_e;

    localparam int SLOT_BYTES_LOG2 = 4;

endpackage

// File: rtl/setclr_decode.sv
// Module: setclr_decode
// Turns an APB address and the phase signals into per-register strobes.
// - A set or clear strobe fires only in a completed write access phase.
// - A read select fires only during a read transfer.
// Assumes the bus decoder has already qualified psel for this window.
// Offset bits above the slot field pick the register; bits [1:0] are ignored.
module setclr_decode
    import setclr_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    output logic [NUM_REGS-1:0] set_en,
    output logic [NUM_REGS-1:0] clr_en,
    output logic [NUM_REGS-1:0] rd_sel
);
    localparam int IDX_W = ADDR_W - SLOT_BYTES_LOG2;

    logic [IDX_W-1:0] slot_idx;
    slot_e            slot_kind;
    logic             wr_commit;
    logic             rd_active;
    logic [1:0]       unused_lo;

    // Split the byte offset into the register index and the alias field.
    always_comb begin
        slot_idx  = paddr[ADDR_W-1:SLOT_BYTES_LOG2];
        slot_kind = slot_e'(paddr[3:2]);
        unused_lo = paddr[1:0];
        wr_commit = psel && penable && pwrite;
        rd_active = psel && !pwrite;
    end

    // One strobe set per register. Indices past NUM_REGS match nothing.
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_slot
        logic idx_match;
        always_comb begin
            idx_match = (slot_idx == IDX_W'(k));
            set_en[k] = wr_commit && idx_match && (slot_kind == SLOT_SET);
            clr_en[k] = wr_commit && idx_match && (slot_kind == SLOT_CLR);
            rd_sel[k] = rd_active && idx_match && (slot_kind == SLOT_READ);
        end
    end

    // R7: at most one alias of one register is strobed per cycle
    p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_en, clr_en}));

endmodule

// File: rtl/setclr_reg.sv
// Module: setclr_reg
// One control register with bitwise set and clear masks.
// Assumes set_en and clr_en are never high in the same cycle; the decoder
// guarantees this. Set takes precedence if both were ever high.
module setclr_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] q
);
    // Store the register. Ones in the mask act on it; zeros leave bits alone.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (set_en) q <= q | mask;
        else if (clr_en) q <= q & ~mask;
    end

    // R2: after a set strobe, the masked bits are 1 and the others keep their value
    p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (((q & $past(mask)) == $past(mask)) &&
                    ((q & ~$past(mask)) == ($past(q) & ~$past(mask)))));

    // R3: after a clear strobe, the masked bits are 0 and the others keep their value
    p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> (((q & $past(mask)) == '0) &&
                    ((q & ~$past(mask)) == ($past(q) & ~$past(mask)))));

    // R6: without a strobe the register holds its value
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en || clr_en) |=> $stable(q));

endmodule

// File: rtl/setclr_rdmux.sv
// Module: setclr_rdmux
// Read-data multiplexer. It returns the register picked by a one-hot select
// and returns zero when nothing is selected.
// Assumes rd_sel is one-hot or all zeros.
module setclr_rdmux #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32
) (
    input  logic [NUM_REGS-1:0]        rd_sel,
    input  logic [NUM_REGS*DATA_W-1:0] q_flat,
    output logic [DATA_W-1:0]          rdata
);
    // AND-OR select, so a missing select yields zero.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_sel[k]) rdata = rdata | q_flat[k*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/setclr_regbank.sv
// Module: setclr_regbank (top)
// APB slave holding NUM_REGS control registers. Each register has set,
// clear and read aliases in a 16-byte slot. The slave has no wait states.
// Writes take effect at the edge that closes the access phase.
// Read data is combinational from the address during a read transfer.
// Assumes the bus decoder drives psel only for this block's window.
module setclr_regbank #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        psel,
    input  logic                        penable,
    input  logic                        pwrite,
    input  logic [ADDR_W-1:0]           paddr,
    input  logic [DATA_W-1:0]           pwdata,
    output logic [DATA_W-1:0]           prdata,
    output logic                        pready,
    output logic [NUM_REGS*DATA_W-1:0]  reg_q
);
    logic [NUM_REGS-1:0] set_en;
    logic [NUM_REGS-1:0] clr_en;
    logic [NUM_REGS-1:0] rd_sel;

    // R8: no wait states, every access completes in its first access cycle
    assign pready = 1'b1;

    // Address and phase decode into per-register strobes.
    setclr_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .set_en  (set_en),
        .clr_en  (clr_en),
        .rd_sel  (rd_sel)
    );

    // One storage element per register, exported in parallel.
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        setclr_reg #(.DATA_W(DATA_W)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (set_en[k]),
            .clr_en (clr_en[k]),
            .mask   (pwdata),
            .q      (reg_q[k*DATA_W +: DATA_W])
        );
    end

    // Read-data selection.
    setclr_rdmux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rdmux (
        .rd_sel (rd_sel),
        .q_flat (reg_q),
        .rdata  (prdata)
    );

    // R6: the bank is stable in any cycle without a completed write access
    p_no_write_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pwrite) |=> $stable(reg_q));

    // R5: non-zero read data only while a read alias is being read
    p_rdata_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prdata != '0) |-> (psel && !pwrite && (paddr[3:2] == 2'd2)));

endmodule

// File: tb/setclr_regbank_bench.sv
// Directed bench for setclr_regbank: one task per scenario, each checking
// its own results against a bench-side model of the registers.
module setclr_regbank_bench;
    localparam int NR = 4;
    localparam int DW = 32;
    localparam int AW = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           psel = 1'b0;
    logic           penable = 1'b0;
    logic           pwrite = 1'b0;
    logic [AW-1:0]  paddr = '0;
    logic [DW-1:0]  pwdata = '0;
    logic [DW-1:0]  prdata;
    logic           pready;
    logic [NR*DW-1:0] reg_q;

    logic [DW-1:0]  model [NR];
    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    setclr_regbank #(.NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW)) u_setclr_regbank (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .pready(pready), .reg_q(reg_q)
    );

    task automatic check(input string req, input logic [DW-1:0] got,
                         input logic [DW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_bank(input string req);
        for (int k = 0; k < NR; k++) check(req, reg_q[k*DW +: DW], model[k]);
    endtask

    // One full write transfer; returns at a falling edge after completion.
    task automatic apb_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; pwdata = '0;
    endtask

    // One full read transfer; samples prdata in the access phase.
    task automatic apb_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    function automatic logic [AW-1:0] a_set(int k);  return AW'(k*16);     endfunction
    function automatic logic [AW-1:0] a_clr(int k);  return AW'(k*16 + 4); endfunction
    function automatic logic [AW-1:0] a_rd(int k);   return AW'(k*16 + 8); endfunction
    function automatic logic [AW-1:0] a_spr(int k);  return AW'(k*16 + 12); endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NR; k++) model[k] = '0;
        check_bank("R1 reset value");
        check("R8 pready", {31'd0, pready}, 32'd1);
    endtask

    task automatic t_set();
        apb_write(a_set(0), 32'h0000_00F0);
        model[0] = model[0] | 32'h0000_00F0;
        check("R2 set from zero", reg_q[0 +: DW], model[0]);
        apb_write(a_set(0), 32'h8000_0001);
        model[0] = model[0] | 32'h8000_0001;
        check("R2 set keeps zero-mask bits", reg_q[0 +: DW], model[0]);
        apb_write(a_set(0), 32'h0);
        check("R2 zero mask no effect", reg_q[0 +: DW], model[0]);
    endtask

    task automatic t_clear();
        apb_write(a_clr(0), 32'h0000_0030);
        model[0] = model[0] & ~32'h0000_0030;
        check("R3 clear bits", reg_q[0 +: DW], model[0]);
        apb_write(a_clr(0), 32'h0);
        check("R3 zero mask no effect", reg_q[0 +: DW], model[0]);
    endtask

    task automatic t_read_alias();
        logic [DW-1:0] d;
        apb_read(a_rd(0), d);
        check("R4 read alias value", d, model[0]);
        apb_write(a_rd(0), 32'hFFFF_FFFF);
        check_bank("R4 write to read alias ignored");
        apb_read(a_rd(0), d);
        check("R4 read after ignored write", d, model[0]);
    endtask

    task automatic t_zero_reads();
        logic [DW-1:0] d;
        apb_read(a_set(0), d);
        check("R5 set alias reads zero", d, 32'h0);
        apb_read(a_clr(0), d);
        check("R5 clear alias reads zero", d, 32'h0);
        apb_read(a_spr(0), d);
        check("R5 spare reads zero", d, 32'h0);
        apb_read(AW'(NR*16 + 8), d);
        check("R5 out-of-range read zero", d, 32'h0);
    endtask

    task automatic t_setup_only();
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1;
        paddr = a_set(1); pwdata = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        psel = 1'b0; pwrite = 1'b0; pwdata = '0;
        check_bank("R6 setup phase only no change");
    endtask

    task automatic t_independence();
        logic [DW-1:0] d;
        for (int k = 0; k < NR; k++) begin
            apb_write(a_set(k), 32'h1111_1111 << k);
            model[k] = model[k] | (32'h1111_1111 << k);
        end
        check_bank("R7 per-register set");
        apb_write(a_clr(2), 32'hFFFF_FFFF);
        model[2] = '0;
        check_bank("R7 clear of one register only");
        for (int k = 0; k < NR; k++) begin
            apb_read(a_rd(k), d);
            check("R7 read alias per register", d, model[k]);
        end
    endtask

    task automatic t_ignored_writes();
        apb_write(a_spr(1), 32'hFFFF_FFFF);
        check_bank("R9 spare write ignored");
        apb_write(AW'(NR*16), 32'hFFFF_FFFF);
        check_bank("R9 out-of-range set ignored");
        apb_write(AW'(NR*16 + 4), 32'hFFFF_FFFF);
        check_bank("R9 out-of-range clear ignored");
    endtask

    initial begin
        t_reset();
        t_set();
        t_clear();
        t_read_alias();
        t_zero_reads();
        t_setup_only();
        t_independence();
        t_ignored_writes();
        check("R8 pready end", {31'd0, pready}, 32'd1);
        t_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule